// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer Channel

This block is one channel of a small general-purpose timer. An 8-bit up-counter advances on every clock cycle in which the count-enable tick is high. Two compare registers, A and B, are checked against the counter. Each compare register raises its own sticky match flag when the counter starts to equal it. A wrap of the counter from its top value back to zero raises an overflow flag. Each of the three flags has an enable bit, and the flag and its enable together form an interrupt request. A control register selects what resets the counter: nothing, match A, match B, or a rising edge on an external reset input. That input is resynchronised inside the channel before use.

Compare-match B also drives a timer output pin. A 2-bit output-select field, kept in the status register, decides whether each B match leaves the pin as it is, forces it low, forces it high, or inverts it. A CPU reaches the channel through a single-cycle register port. Reads are combinational. Writes take effect at the next clock edge. A flag can only be cleared by writing 0 to it after it has been read as 1.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, both compare registers read 0xFF, the counter reads 0x00, the status register reads 0x00, the timer output is low and all interrupt requests are low.
- R2: The counter adds one at each clock edge where `tick` is high and holds where it is low. A CPU write to address 4 loads the counter from `wdata`, and this load takes priority over counting and clearing.
- R3: A counting cycle that moves the counter from 0xFF to 0x00 without a clear sets the overflow flag, which is status bit 5.
- R4: A compare flag is set one cycle after the first cycle in which the counter equals its compare register. Match A is status bit 6 and match B is status bit 7. An equality that persists does not produce further events.
- R5: In a cycle where a compare register (address 2 for A, address 3 for B) is written, that register's equality is treated as false. This applies both to flag setting and to counter clearing.
- R6: Control bits 4:3 choose the clear source. With 00 the counter never clears. With 01 or 10, a counting cycle in which the counter equals compare A or compare B, respectively, loads 0 instead of incrementing.
- R7: With clear source 11, a rising edge on `ext_clr` is seen after two synchronising flops and an edge register. The counter is then cleared on the next counting cycle, and that clear is not flagged as overflow. A pending edge is dropped when the mode is left.
- R8: `irq_cmpb`, `irq_cmpa` and `irq_ovf` are high exactly while their flag is 1 and the matching control bit is 1 (bit 7 for B, bit 6 for A, bit 5 for overflow).
- R9: A status write (address 1) clears a flag only where the written bit is 0 and that flag was read as 1 by an earlier status read. Writing 1, or writing 0 without the earlier read, leaves the flag unchanged.
- R10: If a flag's set event falls in the same cycle as a qualifying clear, the flag stays 1.
- R11: Status bits 1:0 select the action taken by the output on each match-B event: 00 keeps it, 01 drives it low, 10 drives it high, 11 inverts it.
- R12: Reads return the control register at address 0, the status register at address 1 as {flagB, flagA, overflow, 000, output-select}, compare A at 2, compare B at 3, the counter at 4, and 0 elsewhere. Control bits 2:0 are stored and read back with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for this cycle |
| ext_clr | input | 1 | Asynchronous external counter-clear request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_cmpb | output | 1 | Compare-match B interrupt request |
| irq_cmpa | output | 1 | Compare-match A interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| tmr_out | output | 1 | Timer output pin driven by match-B events |

## Verification
The counter is driven in several ways. Bursts with a dense tick and bursts with a sparse random tick separate true counting from holding. Runs that start just below 0xFF isolate the wrap, and compare values placed a few counts ahead of the counter show that each flag rises once and only once. The counter is also parked on a value while the compare register is rewritten with that same value. This exposes whether the write-cycle suppression is present, because suppression turns a steady equality into a fresh event. Each clear mode is then run against short compare periods and against `ext_clr` pulses with a sparse tick, which tells an immediate clear apart from a clear that waits for the next count. A long mixed phase lets status reads, writes of 0 and writes of 1 land on the same cycles as match events, so the set-beats-clear rule and the read-before-clear rule get exercised.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_STAT = 3'd1;
    localparam logic [AW-1:0] A_CMPA = 3'd2;
    localparam logic [AW-1:0] A_CMPB = 3'd3;
    localparam logic [AW-1:0] A_CNT  = 3'd4;

    // flag index i lives at status bit ST_BASE+i : 0 overflow, 1 match A, 2 match B
    localparam int NFLAG   = 3;
    localparam int ST_BASE = 5;
    localparam int F_OVF   = 0;
    localparam int F_A     = 1;
    localparam int F_B     = 2;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_CMPA = 2'b01,
        CLR_CMPB = 2'b10,
        CLR_EXT  = 2'b11
    } clr_mode_e;

    typedef enum logic [1:0] {
        OUT_KEEP   = 2'b00,
        OUT_LOW    = 2'b01,
        OUT_HIGH   = 2'b10,
        OUT_TOGGLE = 2'b11
    } out_sel_e;

    typedef struct packed {
        logic      ie_b;
        logic      ie_a;
        logic      ie_ovf;
        clr_mode_e clr;
        logic [2:0] cks;
    } ctrl_t;

    function automatic logic pin_next(out_sel_e sel, logic cur);
        case (sel)
            OUT_LOW:    return 1'b0;
            OUT_HIGH:   return 1'b1;
            OUT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output ctrl_t         ctrl,
    output logic [W-1:0]  cmpa,
    output logic [W-1:0]  cmpb,
    output out_sel_e      osel,
    output logic          wr_cmpa,
    output logic          wr_cmpb,
    output logic          wr_cnt,
    output logic          wr_stat
);

    logic wr_ctrl;

    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_stat = wr_en && (addr == A_STAT);
        wr_cmpa = wr_en && (addr == A_CMPA);
        wr_cmpb = wr_en && (addr == A_CMPB);
        wr_cnt  = wr_en && (addr == A_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmpa <= '1;
            cmpb <= '1;
            osel <= OUT_KEEP;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[7:0]);
            if (wr_cmpa) cmpa <= wdata;
            if (wr_cmpb) cmpb <= wdata;
            if (wr_stat) osel <= out_sel_e'(wdata[1:0]);
        end
    end

    assert_cmpb_load_R12: assert property (@(posedge clk) disable iff (rst)
        wr_cmpb |=> (cmpb == $past(wdata)));

    assert_osel_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> $stable(osel));

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         wr_hit,
    output logic         eq,
    output logic         ev
);

    logic eq_q;

    // a write to the compare register masks the equality for that cycle
    assign eq = (cnt == cmp) && !wr_hit;
    assign ev = eq && !eq_q;

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    assert_single_event_R4: assert property (@(posedge clk) disable iff (rst)
        ev |=> !ev);

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int W    = DW,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ext_clr,
    input  clr_mode_e    mode,
    input  logic         eq_a,
    input  logic         eq_b,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf_ev
);

    logic [SYNC-1:0] sync_q;
    logic            sync_last;
    logic            ext_edge;
    logic            pend_q;
    logic            clr_hit;

    generate
        if (SYNC == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_clr;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC-2:0], ext_clr};
            end
        end
    endgenerate

    assign ext_edge = sync_q[SYNC-1] && !sync_last;

    always_comb begin
        case (mode)
            CLR_CMPA: clr_hit = eq_a;
            CLR_CMPB: clr_hit = eq_b;
            CLR_EXT:  clr_hit = pend_q;
            default:  clr_hit = 1'b0;
        endcase
    end

    assign ovf_ev = tick && !wr_cnt && !clr_hit && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_last <= 1'b0;
            pend_q    <= 1'b0;
            cnt       <= '0;
        end else begin
            sync_last <= sync_q[SYNC-1];
            pend_q    <= (mode == CLR_EXT) && (ext_edge || (pend_q && !tick));
            if (wr_cnt)    cnt <= wdata;
            else if (tick) cnt <= clr_hit ? '0 : cnt + 1'b1;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(cnt));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> (cnt == '0));

    assert_ext_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == CLR_EXT && pend_q && tick && !wr_cnt) |=> (cnt == '0));

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags
    import tmr8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_ev,
    input  logic [NFLAG-1:0] ie,
    input  logic             rd_stat,
    input  logic             wr_stat,
    input  logic [W-1:0]     wdata,
    input  logic             ev_b,
    input  out_sel_e         osel,
    output logic [NFLAG-1:0] flag,
    output logic [NFLAG-1:0] irq,
    output logic             pin
);

    logic [NFLAG-1:0] arm;

    genvar i;
    generate
        for (i = 0; i < NFLAG; i++) begin : g_flag
            logic clr_ok;
            assign clr_ok = wr_stat && arm[i] && !wdata[ST_BASE+i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flag[i] <= 1'b0;
                    arm[i]  <= 1'b0;
                end else begin
                    if (set_ev[i])   flag[i] <= 1'b1;
                    else if (clr_ok) flag[i] <= 1'b0;
                    if (clr_ok)               arm[i] <= 1'b0;
                    else if (rd_stat && flag[i]) arm[i] <= 1'b1;
                end
            end

            assign irq[i] = flag[i] && ie[i];

            assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
                set_ev[i] |=> flag[i]);

            assert_unarmed_keep_R9: assert property (@(posedge clk) disable iff (rst)
                (wr_stat && !arm[i] && !set_ev[i]) |=> (flag[i] == $past(flag[i])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       pin <= 1'b0;
        else if (ev_b) pin <= pin_next(osel, pin);
    end

    assert_pin_low_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_b && osel == OUT_LOW) |=> !pin);

    assert_pin_high_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_b && osel == OUT_HIGH) |=> pin);

    assert_pin_toggle_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_b && osel == OUT_TOGGLE) |=> (pin != $past(pin)));

    assert_pin_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !ev_b |=> $stable(pin));

endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
    import tmr8_pkg::*;
#(
    parameter int W    = DW,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ext_clr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq_cmpb,
    output logic          irq_cmpa,
    output logic          irq_ovf,
    output logic          tmr_out
);

    localparam int NCMP = 2;

    ctrl_t            ctrl;
    out_sel_e         osel;
    logic [W-1:0]     cmpa, cmpb, cnt;
    logic             wr_cmpa, wr_cmpb, wr_cnt, wr_stat;
    logic             ovf_ev;
    logic [W-1:0]     cmp_v  [NCMP];
    logic [NCMP-1:0]  wr_v, eq_v, ev_v;
    logic [NFLAG-1:0] set_ev, ie, flag, irq;

    tmr8_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl(ctrl), .cmpa(cmpa), .cmpb(cmpb), .osel(osel),
        .wr_cmpa(wr_cmpa), .wr_cmpb(wr_cmpb), .wr_cnt(wr_cnt), .wr_stat(wr_stat)
    );

    assign cmp_v[0] = cmpa;
    assign cmp_v[1] = cmpb;
    assign wr_v     = {wr_cmpb, wr_cmpa};

    genvar c;
    generate
        for (c = 0; c < NCMP; c++) begin : g_cmp
            tmr8_cmp #(.W(W)) cmp_i (
                .clk(clk), .rst(rst), .cnt(cnt), .cmp(cmp_v[c]),
                .wr_hit(wr_v[c]), .eq(eq_v[c]), .ev(ev_v[c])
            );
        end
    endgenerate

    tmr8_counter #(.W(W), .SYNC(SYNC)) cnt_i (
        .clk(clk), .rst(rst), .tick(tick), .ext_clr(ext_clr), .mode(ctrl.clr),
        .eq_a(eq_v[0]), .eq_b(eq_v[1]), .wr_cnt(wr_cnt), .wdata(wdata),
        .cnt(cnt), .ovf_ev(ovf_ev)
    );

    assign set_ev = {ev_v[1], ev_v[0], ovf_ev};
    assign ie     = {ctrl.ie_b, ctrl.ie_a, ctrl.ie_ovf};

    tmr8_flags #(.W(W)) flags_i (
        .clk(clk), .rst(rst), .set_ev(set_ev), .ie(ie),
        .rd_stat(rd_en && addr == A_STAT), .wr_stat(wr_stat), .wdata(wdata),
        .ev_b(ev_v[1]), .osel(osel), .flag(flag), .irq(irq), .pin(tmr_out)
    );

    assign irq_cmpb = irq[F_B];
    assign irq_cmpa = irq[F_A];
    assign irq_ovf  = irq[F_OVF];

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata[7:0] = ctrl;
            A_STAT: rdata[7:0] = {flag[F_B], flag[F_A], flag[F_OVF], 3'b000, osel};
            A_CMPA: rdata = cmpa;
            A_CMPB: rdata = cmpb;
            A_CNT:  rdata = cnt;
            default: rdata = '0;
        endcase
    end

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_cmpa) |-> (flag[F_A] && ctrl.ie_a));

    assert_reset_cmp_R1: assert property (@(posedge clk)
        $past(rst) |-> (cmpb == '1 && cnt == '0 && !tmr_out));

endmodule

// File: tb/tmr8_dual_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_dual_cmp_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick, ext_clr, wr_en, rd_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq_cmpb, irq_cmpa, irq_ovf, tmr_out;

    always #2 clk = ~clk;

    tmr8_dual_cmp dut_i (
        .clk(clk), .rst(rst), .tick(tick), .ext_clr(ext_clr),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_cmpb(irq_cmpb), .irq_cmpa(irq_cmpa),
        .irq_ovf(irq_ovf), .tmr_out(tmr_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    string tag = "R1";
    logic [7:0] last_rd;

    // reference state
    int m_ctrl, m_cmpa, m_cmpb, m_cnt, m_osel, m_out;
    int m_fa, m_fb, m_fo, arm_a, arm_b, arm_o;
    int eqa_q, eqb_q, s1, s2, s3, pend;

    function automatic int ref_rdata(int a);
        case (a)
            0: return m_ctrl;
            1: return m_fb*128 + m_fa*64 + m_fo*32 + m_osel;
            2: return m_cmpa;
            3: return m_cmpb;
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 0; m_cmpa = 255; m_cmpb = 255; m_cnt = 0; m_osel = 0; m_out = 0;
        m_fa = 0; m_fb = 0; m_fo = 0; arm_a = 0; arm_b = 0; arm_o = 0;
        eqa_q = 0; eqb_q = 0; s1 = 0; s2 = 0; s3 = 0; pend = 0;
    endtask

    task automatic check(int got, int exp, string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_step(int t, int e, int w, int r, int a, int d);
        int eqa, eqb, eva, evb, mode, edge_s, clr, wcnt, ovfev, st_w, st_r;
        int ca, cb, co;
        mode  = (m_ctrl / 8) % 4;
        eqa   = (m_cnt == m_cmpa) && !(w && a == 2);
        eqb   = (m_cnt == m_cmpb) && !(w && a == 3);
        eva   = eqa && !eqa_q;
        evb   = eqb && !eqb_q;
        edge_s = s2 && !s3;
        clr   = (mode == 1 && eqa) || (mode == 2 && eqb) || (mode == 3 && pend);
        wcnt  = w && a == 4;
        ovfev = t && !wcnt && !clr && m_cnt == 255;
        st_w  = w && a == 1;
        st_r  = r && a == 1;
        ca = st_w && arm_a && ((d >> 6) % 2 == 0);
        cb = st_w && arm_b && ((d >> 7) % 2 == 0);
        co = st_w && arm_o && ((d >> 5) % 2 == 0);
        if (evb) begin
            case (m_osel)
                1: m_out = 0;
                2: m_out = 1;
                3: m_out = 1 - m_out;
                default: ;
            endcase
        end
        if (ca) arm_a = 0; else if (st_r && m_fa) arm_a = 1;
        if (cb) arm_b = 0; else if (st_r && m_fb) arm_b = 1;
        if (co) arm_o = 0; else if (st_r && m_fo) arm_o = 1;
        if (eva) m_fa = 1; else if (ca) m_fa = 0;
        if (evb) m_fb = 1; else if (cb) m_fb = 0;
        if (ovfev) m_fo = 1; else if (co) m_fo = 0;
        if (wcnt) m_cnt = d;
        else if (t) m_cnt = clr ? 0 : (m_cnt + 1) % 256;
        pend = (mode == 3) && (edge_s || (pend && !t));
        s3 = s2; s2 = s1; s1 = e;
        eqa_q = eqa; eqb_q = eqb;
        if (st_w)        m_osel = d % 4;
        if (w && a == 0) m_ctrl = d;
        if (w && a == 2) m_cmpa = d;
        if (w && a == 3) m_cmpb = d;
    endtask

    task automatic cyc(int t, int e, int w, int r, int a, int d);
        @(negedge clk);
        tick = t[0]; ext_clr = e[0]; wr_en = w[0]; rd_en = r[0];
        addr = a[2:0]; wdata = d[7:0];
        #1;
        last_rd = rdata;
        check(rdata, ref_rdata(a), "rdata");
        check(irq_cmpb, m_fb && ((m_ctrl >> 7) % 2), "irq_cmpb");
        check(irq_cmpa, m_fa && ((m_ctrl >> 6) % 2), "irq_cmpa");
        check(irq_ovf,  m_fo && ((m_ctrl >> 5) % 2), "irq_ovf");
        check(tmr_out, m_out, "tmr_out");
        model_step(t, e, w, r, a, d);
    endtask

    task automatic wr(int a, int d);  cyc(0, ext_clr, 1, 0, a, d); endtask
    task automatic rd(int a);         cyc(0, ext_clr, 0, 1, a, 0); endtask
    task automatic run(int n, int pct);
        for (int k = 0; k < n; k++) cyc(($urandom % 100) < pct, ext_clr, 0, 0, 4, 0);
    endtask
    task automatic mix(int n, int mx);
        for (int k = 0; k < n; k++) begin
            int op = $urandom % 10;
            int ad = $urandom % 6;
            int dv = $urandom % 256;
            if (ad == 4 || ad == 2 || ad == 3) dv = dv % mx;
            if (ad == 4 && op < 2) dv = mx - 1;
            cyc($urandom % 2, ($urandom % 8) < 3, op < 2, op >= 5, ad, dv);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick = 0; ext_clr = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values
        tag = "R1";
        rd(0); check(last_rd, 8'h00, "ctrl reset");
        rd(2); check(last_rd, 8'hFF, "cmpa reset");
        rd(3); check(last_rd, 8'hFF, "cmpb reset");
        rd(4); check(last_rd, 8'h00, "cnt reset");
        rd(1); check(last_rd, 8'h00, "status reset");

        // R2 counting, holding and loading
        tag = "R2";
        run(20, 100); run(30, 30);
        wr(4, 8'h30); rd(4); check(last_rd, 8'h30, "cnt load");
        cyc(1, 0, 1, 0, 4, 8'h77); rd(4); check(last_rd, 8'h77, "load beats tick");

        // R3 overflow
        tag = "R3";
        wr(4, 8'hFA); run(10, 100);
        rd(1); check(last_rd[5], 1, "ovf flag");

        // R4 compare events
        tag = "R4";
        wr(2, 8'h20); wr(3, 8'h28); wr(4, 8'h1C); run(20, 100);
        rd(1); check(last_rd[7:6], 2'b11, "both match flags");

        // R5 write-cycle suppression
        tag = "R5";
        rd(1); wr(1, 0); wr(4, 8'h40); wr(3, 8'h40); run(3, 0);
        rd(1); wr(1, 0); run(2, 0);
        wr(3, 8'h40); run(2, 0);
        rd(1); check(last_rd[7], 1, "rewrite gives event");
        wr(4, 8'h50); run(1, 0); cyc(1, 0, 1, 0, 2, 8'h51); run(4, 100);

        // R6 clear modes
        tag = "R6";
        wr(0, 8'h08); wr(2, 8'h05); wr(4, 0); run(30, 100); run(20, 40);
        wr(0, 8'h10); wr(3, 8'h07); run(30, 100);
        wr(0, 8'h00); run(20, 100);

        // R7 external clear
        tag = "R7";
        wr(0, 8'h18); wr(4, 8'h10);
        for (int k = 0; k < 80; k++) cyc(($urandom % 4) == 0, (k % 10) < 4, 0, 0, 4, 0);
        cyc(0, 0, 0, 0, 4, 0); wr(0, 8'h00); run(10, 100);

        // R8 interrupt gating
        tag = "R8";
        for (int k = 0; k < 40; k++) begin
            wr(0, ($urandom % 8) * 32 + $urandom % 8);
            run(3, 80);
        end

        // R9 read-before-clear
        tag = "R9";
        wr(0, 8'h00); rd(1); wr(1, 0);
        wr(4, 8'h60); wr(2, 8'h60); run(3, 0);
        wr(1, 8'h00); rd(1); check(last_rd[6], 1, "unarmed clear ignored");
        wr(1, 8'hE0); rd(1); check(last_rd[6], 1, "write 1 ignored");
        wr(1, 8'h00); rd(1); check(last_rd[6], 0, "armed clear");

        // R11 output select
        tag = "R11";
        for (int s = 0; s < 4; s++) begin
            wr(1, s); wr(3, 8'h90); wr(4, 8'h8E);
            run(4, 100); run(2, 100);
        end
        wr(1, 3); wr(3, 8'h10); wr(0, 8'h10); wr(4, 0); run(60, 100);

        // R10 set against clear, mixed traffic
        tag = "R10";
        mix(600, 8);

        // R12 readback and long mix
        tag = "R12";
        wr(0, 8'hA7); rd(0); check(last_rd, 8'hA7, "ctrl readback");
        rd(6); check(last_rd, 8'h00, "unmapped read");
        mix(3000, 256);
        mix(3000, 12);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule